// File: doc/BRIEF.md
# Escape-Marker Hexadecimal Run-Length Expander

This block turns a compressed stream of 4-bit hexadecimal digits back into the original digit stream. One digit value is reserved as an escape. Any other digit seen between groups is copied straight to the output. When the escape digit shows up, it opens a four-digit group made of the escape, the digit to repeat, and an 8-bit repeat count written as two hexadecimal digits. The group is replaced by that digit repeated count times. The repeated digit may be the escape value itself, so an escape digit in the original data survives compression.

Both sides move one digit per cycle under a valid/ready handshake. Each side carries a flag that marks the end of a frame. While a run is being expanded the block refuses new input. A stalled output freezes the expansion without losing digits. A frame that ends inside a group, or a group whose count is zero, is reported by a one-cycle error pulse, after which parsing starts over in the literal state.

Top module: `rle_hex_expander`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `err_pulse` are 0 and `in_ready` is 1. This also holds when reset arrives in the middle of an expansion.
- R2: An accepted digit other than the escape value 0xA, outside a group, appears exactly once on the output, in input order.
- R3: After an escape, the next accepted digit is the symbol and the two after it are the count, high digit first. The symbol is then emitted exactly count times, for any count from 1 to 255.
- R4: The symbol of a group may be 0xA itself. A A 0 3 produces three 0xA digits.
- R5: During an expansion `in_ready` is 0. The next input digit is accepted only after the last repeat of the run has been presented on the output.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_digit` and `out_last` stay unchanged and no digit is lost.
- R7: `out_last` is 1 on exactly one output digit: the final one produced by the input digit or group that carried `in_last`.
- R8: If `in_last` is accepted before a group has its fourth digit, `err_pulse` is high for one cycle, no output is produced for that group, and the next digit is parsed as a literal.
- R9: A group with count 00 emits no digit and raises the same one-cycle `err_pulse`.
- R10: The stream A014FFA011AA03AF08 expands to 20 zeros, 2 F, 17 zeros, 3 A and 8 F, 50 digits in all.
- R11: A literal accepted at a clock edge is on the output after that same edge. The first repeat of a group is on the output one edge after the count's low digit is accepted. Further repeats follow on each edge while `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input digit is valid |
| in_ready | output | 1 | Block accepts the input digit this cycle |
| in_digit | input | 4 | Compressed input digit |
| in_last | input | 1 | Input digit ends the frame |
| out_valid | output | 1 | Output digit is valid |
| out_ready | input | 1 | Downstream accepts the output digit |
| out_digit | output | 4 | Expanded output digit |
| out_last | output | 1 | Final expanded digit of the frame |
| err_pulse | output | 1 | One-cycle pulse on a truncated group or zero count |

## Verification
A literal is visible after the edge that accepts it. An expansion shows nothing after the edge that takes the count's low digit, and its first repeat appears one edge later. The latency tests sample at the falling edge after each of these rising edges and compare against those exact positions. The general vectors hold `out_ready` high and count an output transfer at each falling edge where valid and ready are both high. Each table row then waits long enough for the longest run before it compares counts, digit sums, end flags and error pulses. The stall test holds `out_ready` low for several cycles and checks the held digit at every falling edge.

// File: rtl/rlx_pkg.sv
// Shared types for the run-length expander.
package rlx_pkg;
    // Parser phase: literal scan, group fields, run expansion.
    typedef enum logic [2:0] {
        ST_LIT  = 3'd0,
        ST_SYM  = 3'd1,
        ST_CHI  = 3'd2,
        ST_CLO  = 3'd3,
        ST_RUN  = 3'd4
    } rlx_state_e;
endpackage

// File: rtl/rlx_group_parser.sv
// Group parser: classifies input digits as literals or escape groups,
// captures symbol and count, and starts runs.
// Assumes the output stage reports out_free and the run counter reports
// run_done on the cycle that loads the final repeat.
module rlx_group_parser
    import rlx_pkg::*;
#(
    parameter int DIGIT_W = 4,
    parameter logic [DIGIT_W-1:0] MARKER = 'hA,
    localparam int CNT_W = 2 * DIGIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DIGIT_W-1:0] in_digit,
    input  logic               in_last,
    output logic               in_ready,
    input  logic               out_free,
    input  logic               run_done,
    output rlx_state_e         state_o,
    output logic               lit_load,
    output logic [DIGIT_W-1:0] lit_digit,
    output logic               lit_last,
    output logic               run_load,
    output logic [DIGIT_W-1:0] run_sym,
    output logic [CNT_W-1:0]   run_count,
    output logic               run_last,
    output logic               err_pulse
);
    rlx_state_e         state_q, state_d;
    logic [DIGIT_W-1:0] sym_q, hi_q;
    logic               err_q, err_d;
    logic               accept;
    logic [CNT_W-1:0]   count_w;

    // Literal scan needs output room; group fields do not; runs block input.
    always_comb begin
        case (state_q)
            ST_LIT:  in_ready = out_free;
            ST_RUN:  in_ready = 1'b0;
            default: in_ready = 1'b1;
        endcase
    end

    assign accept  = in_valid && in_ready;
    assign count_w = {hi_q, in_digit};

    // Next-state and action decode for each phase.
    always_comb begin
        state_d  = state_q;
        err_d    = 1'b0;
        lit_load = 1'b0;
        run_load = 1'b0;
        case (state_q)
            ST_LIT: begin
                if (accept) begin
                    if (in_digit == MARKER) begin
                        if (in_last) err_d = 1'b1;
                        else         state_d = ST_SYM;
                    end else begin
                        lit_load = 1'b1;
                    end
                end
            end
            ST_SYM: begin
                if (accept) begin
                    if (in_last) begin
                        err_d   = 1'b1;
                        state_d = ST_LIT;
                    end else begin
                        state_d = ST_CHI;
                    end
                end
            end
            ST_CHI: begin
                if (accept) begin
                    if (in_last) begin
                        err_d   = 1'b1;
                        state_d = ST_LIT;
                    end else begin
                        state_d = ST_CLO;
                    end
                end
            end
            ST_CLO: begin
                if (accept) begin
                    if (count_w == '0) begin
                        err_d   = 1'b1;
                        state_d = ST_LIT;
                    end else begin
                        run_load = 1'b1;
                        state_d  = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (run_done) state_d = ST_LIT;
            end
            default: state_d = ST_LIT;
        endcase
    end

    // Phase register and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LIT;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    // Capture symbol and high count digit as they arrive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q <= '0;
            hi_q  <= '0;
        end else if (accept) begin
            if (state_q == ST_SYM) sym_q <= in_digit;
            if (state_q == ST_CHI) hi_q  <= in_digit;
        end
    end

    assign state_o   = state_q;
    assign lit_digit = in_digit;
    assign lit_last  = in_last;
    assign run_sym   = sym_q;
    assign run_count = count_w;
    assign run_last  = in_last;
    assign err_pulse = err_q;

    AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (state_q == ST_LIT)); // R8
    AST_HI_AFTER_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHI) |-> ($past(state_q) == ST_SYM || $past(state_q) == ST_CHI)); // R3
    AST_RUN_FROM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RUN) |-> $past(run_load)); // R3
endmodule

// File: rtl/rlx_run_counter.sv
// Run counter: holds the symbol, the remaining repeat count and the
// frame-end flag of one group, and emits one repeat per free output slot.
// Assumes load is only raised when no run is active and count is nonzero.
module rlx_run_counter #(
    parameter int DIGIT_W = 4,
    localparam int CNT_W = 2 * DIGIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DIGIT_W-1:0] load_sym,
    input  logic [CNT_W-1:0]   load_cnt,
    input  logic               load_last,
    input  logic               active,
    input  logic               out_free,
    output logic               rep_emit,
    output logic [DIGIT_W-1:0] rep_digit,
    output logic               rep_last,
    output logic               run_done
);
    logic [CNT_W-1:0]   rem_q;
    logic [DIGIT_W-1:0] sym_q;
    logic               last_q;
    logic               final_rep;

    assign final_rep = (rem_q == CNT_W'(1));
    assign rep_emit  = active && out_free;
    assign rep_digit = sym_q;
    assign rep_last  = last_q && final_rep;
    assign run_done  = rep_emit && final_rep;

    // Load a new run or count one emitted repeat down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            sym_q  <= '0;
            last_q <= 1'b0;
        end else if (load) begin
            rem_q  <= load_cnt;
            sym_q  <= load_sym;
            last_q <= load_last;
        end else if (rep_emit) begin
            rem_q  <= rem_q - CNT_W'(1);
        end
    end

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (rem_q != '0)); // R3
    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !active); // R5
    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_cnt != '0)); // R9
endmodule

// File: rtl/rlx_out_stage.sv
// Output stage: one registered digit slot fed by either the literal path
// or the run counter, held while the consumer stalls.
// Assumes at most one source loads per cycle and only when out_free is 1.
module rlx_out_stage #(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lit_load,
    input  logic [DIGIT_W-1:0] lit_digit,
    input  logic               lit_last,
    input  logic               rep_emit,
    input  logic [DIGIT_W-1:0] rep_digit,
    input  logic               rep_last,
    input  logic               out_ready,
    output logic               out_free,
    output logic               out_valid,
    output logic [DIGIT_W-1:0] out_digit,
    output logic               out_last
);
    logic               vld_q;
    logic [DIGIT_W-1:0] dig_q;
    logic               lst_q;

    assign out_free  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_digit = dig_q;
    assign out_last  = lst_q;

    // Fill the slot from the active source, or empty it once taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dig_q <= '0;
            lst_q <= 1'b0;
        end else if (lit_load) begin
            vld_q <= 1'b1;
            dig_q <= lit_digit;
            lst_q <= lit_last;
        end else if (rep_emit) begin
            vld_q <= 1'b1;
            dig_q <= rep_digit;
            lst_q <= rep_last;
        end else if (out_ready) begin
            vld_q <= 1'b0;
            lst_q <= 1'b0;
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_digit) && $stable(out_last))); // R6
    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(lit_load && rep_emit)); // R5
    AST_LOAD_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (lit_load || rep_emit) |-> out_free); // R6
endmodule

// File: rtl/rle_hex_expander.sv
// Top of the escape-marker run-length expander: parser, run counter and
// output slot. One digit in and one digit out per cycle at most.
// Assumes a synchronous active-low reset and a single clock domain.
module rle_hex_expander
    import rlx_pkg::*;
#(
    parameter int DIGIT_W = 4,
    parameter logic [DIGIT_W-1:0] MARKER = 'hA,
    localparam int CNT_W = 2 * DIGIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DIGIT_W-1:0] in_digit,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DIGIT_W-1:0] out_digit,
    output logic               out_last,
    output logic               err_pulse
);
    rlx_state_e         state_w;
    logic               out_free_w, run_done_w;
    logic               lit_load_w, lit_last_w;
    logic [DIGIT_W-1:0] lit_digit_w;
    logic               run_load_w, run_last_w;
    logic [DIGIT_W-1:0] run_sym_w;
    logic [CNT_W-1:0]   run_count_w;
    logic               rep_emit_w, rep_last_w;
    logic [DIGIT_W-1:0] rep_digit_w;
    logic               run_active_w;

    assign run_active_w = (state_w == ST_RUN);

    rlx_group_parser #(.DIGIT_W(DIGIT_W), .MARKER(MARKER)) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_digit  (in_digit),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_free  (out_free_w),
        .run_done  (run_done_w),
        .state_o   (state_w),
        .lit_load  (lit_load_w),
        .lit_digit (lit_digit_w),
        .lit_last  (lit_last_w),
        .run_load  (run_load_w),
        .run_sym   (run_sym_w),
        .run_count (run_count_w),
        .run_last  (run_last_w),
        .err_pulse (err_pulse)
    );

    rlx_run_counter #(.DIGIT_W(DIGIT_W)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (run_load_w),
        .load_sym  (run_sym_w),
        .load_cnt  (run_count_w),
        .load_last (run_last_w),
        .active    (run_active_w),
        .out_free  (out_free_w),
        .rep_emit  (rep_emit_w),
        .rep_digit (rep_digit_w),
        .rep_last  (rep_last_w),
        .run_done  (run_done_w)
    );

    rlx_out_stage #(.DIGIT_W(DIGIT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .lit_load  (lit_load_w),
        .lit_digit (lit_digit_w),
        .lit_last  (lit_last_w),
        .rep_emit  (rep_emit_w),
        .rep_digit (rep_digit_w),
        .rep_last  (rep_last_w),
        .out_ready (out_ready),
        .out_free  (out_free_w),
        .out_valid (out_valid),
        .out_digit (out_digit),
        .out_last  (out_last)
    );

    AST_NO_INPUT_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        rep_emit_w |-> !(in_valid && in_ready)); // R5
    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R7
endmodule

// File: tb/rle_hex_expander_tb.sv
module rle_hex_expander_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] in_digit = '0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [3:0] out_digit;
    logic       out_last;
    logic       err_pulse;

    always #4 clk = ~clk; // 125 MHz

    rle_hex_expander u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_digit(in_digit), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_digit(out_digit), .out_last(out_last),
        .err_pulse(err_pulse)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Output monitor: counts transfers at falling edges.
    int m_cnt, m_sum, m_err, m_lastn, m_lastidx, acc_mcnt;
    logic [3:0] m_buf [0:255];
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (m_cnt < 256) m_buf[m_cnt] = out_digit;
                m_sum = m_sum + int'(out_digit);
                if (out_last) begin
                    m_lastn = m_lastn + 1;
                    m_lastidx = m_cnt;
                end
                m_cnt = m_cnt + 1;
            end
            if (err_pulse) m_err = m_err + 1;
        end
    end

    task automatic mon_clear();
        m_cnt = 0; m_sum = 0; m_err = 0; m_lastn = 0; m_lastidx = -1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] d, input logic l);
        bit acc;
        in_valid = 1'b1; in_digit = d; in_last = l;
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk); #1;
        end while (!acc);
        acc_mcnt = m_cnt;
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    // Vector table: stimulus nibbles (first in the top bits), length,
    // expected count, digit sum, error pulses, expected out_last flags.
    localparam int NV = 7;
    localparam logic [31:0] TV_STIM [0:NV-1] = '{
        32'h53700000, 32'hA4050000, 32'hAA030000, 32'h1A21090_0,
        32'hA6000000, 32'h3A600000, 32'hAFFF0000 };
    localparam int TV_LEN  [0:NV-1] = '{3, 4, 4, 6, 4, 3, 4};
    localparam int TV_CNT  [0:NV-1] = '{3, 5, 3, 18, 0, 1, 255};
    localparam int TV_SUM  [0:NV-1] = '{15, 20, 30, 42, 0, 3, 3825};
    localparam int TV_ERR  [0:NV-1] = '{0, 0, 0, 0, 1, 1, 0};
    localparam int TV_LAST [0:NV-1] = '{1, 1, 1, 1, 0, 0, 1};
    localparam string TV_REQ [0:NV-1] = '{"R2", "R3", "R4", "R3", "R9", "R8", "R3"};

    localparam logic [71:0] EX_STIM = 72'hA014FFA011AA03AF08;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        mon_clear();
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state right after reset
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(err_pulse == 1'b0, "R1 err_pulse", int'(err_pulse), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        @(posedge clk); #1;

        // Table walk with out_ready held high.
        for (int v = 0; v < NV; v++) begin
            mon_clear();
            for (int i = 0; i < TV_LEN[v]; i++)
                send(TV_STIM[v][31-4*i -: 4], i == TV_LEN[v] - 1);
            repeat (TV_CNT[v] + 10) @(posedge clk); #1;
            chk(m_cnt == TV_CNT[v], {TV_REQ[v], " count"}, m_cnt, TV_CNT[v]);
            chk(m_sum == TV_SUM[v], {TV_REQ[v], " sum"}, m_sum, TV_SUM[v]);
            chk(m_err == TV_ERR[v], {TV_REQ[v], " R8/R9 errors"}, m_err, TV_ERR[v]);
            chk(m_lastn == TV_LAST[v] && (TV_LAST[v] == 0 || m_lastidx == TV_CNT[v] - 1),
                {TV_REQ[v], " R7 last"}, m_lastidx, TV_CNT[v] - 1);
        end

        // R10: full example stream, digit by digit.
        begin
            int bad = 0;
            int idx = 0;
            int rl [0:4] = '{20, 2, 17, 3, 8};
            logic [3:0] rd [0:4] = '{4'h0, 4'hF, 4'h0, 4'hA, 4'hF};
            mon_clear();
            for (int i = 0; i < 18; i++) send(EX_STIM[71-4*i -: 4], i == 17);
            repeat (40) @(posedge clk); #1;
            for (int r = 0; r < 5; r++)
                for (int k = 0; k < rl[r]; k++) begin
                    if (m_buf[idx] != rd[r]) bad++;
                    idx++;
                end
            chk(m_cnt == 50, "R10 count", m_cnt, 50);
            chk(bad == 0, "R10 digit mismatches", bad, 0);
            chk(m_lastn == 1 && m_lastidx == 49, "R10 R7 last index", m_lastidx, 49);
        end

        // R5: next digit accepted only after all five repeats are out.
        mon_clear();
        send(4'hA, 1'b0); send(4'h3, 1'b0); send(4'h0, 1'b0); send(4'h5, 1'b0);
        send(4'h9, 1'b1);
        chk(acc_mcnt == 5, "R5 outputs before next accept", acc_mcnt, 5);
        repeat (5) @(posedge clk); #1;
        chk(m_cnt == 6 && m_buf[5] == 4'h9, "R5 trailing literal", int'(m_buf[5]), 9);

        // R11: literal latency, then group latency.
        mon_clear();
        send(4'h5, 1'b1);
        @(negedge clk);
        chk(out_valid && out_digit == 4'h5 && out_last, "R11 literal next cycle", int'(out_digit), 5);
        repeat (3) @(posedge clk); #1;
        send(4'hA, 1'b0); send(4'h7, 1'b0); send(4'h0, 1'b0); send(4'h2, 1'b1);
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 no output on first cycle", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid && out_digit == 4'h7 && !out_last, "R11 first repeat", int'(out_digit), 7);
        @(negedge clk);
        chk(out_valid && out_digit == 4'h7 && out_last, "R11 R7 second repeat last", int'(out_last), 1);
        repeat (3) @(posedge clk); #1;

        // R6: stall output during a run.
        begin
            int hold_bad = 0;
            mon_clear();
            out_ready = 1'b0;
            send(4'hA, 1'b0); send(4'h3, 1'b0); send(4'h0, 1'b0); send(4'h4, 1'b1);
            @(negedge clk);
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (!(out_valid && out_digit == 4'h3 && !out_last)) hold_bad++;
            end
            chk(hold_bad == 0, "R6 held digit during stall", hold_bad, 0);
            @(posedge clk); #1;
            out_ready = 1'b1;
            repeat (10) @(posedge clk); #1;
            chk(m_cnt == 4 && m_sum == 12, "R6 no loss after stall", m_cnt, 4);
        end

        // R1: reset in the middle of a long run.
        mon_clear();
        send(4'hA, 1'b0); send(4'h5, 1'b0); send(4'hF, 1'b0); send(4'hF, 1'b1);
        repeat (4) @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset mid-run", int'(out_valid), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        mon_clear();
        send(4'h6, 1'b1);
        repeat (3) @(posedge clk); #1;
        chk(m_cnt == 1 && m_buf[0] == 4'h6, "R1 R2 literal after reset", m_cnt, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule